// File: doc/BRIEF.md
# Instruction Format Decoder

This block sorts a 16-bit instruction word, built from four hex nibbles, into one of six instruction classes. It pulls out the fields each class carries: opcode, destination and source register-or-mode fields, their memory flags, an 8-bit constant and an 8-bit branch offset. It reports when the instruction needs a second 16-bit word from the stream, and when the word holds an opcode value with no defined meaning.

The decode logic is combinational and is followed by a single output register. The result for a word presented with `instr_valid` high appears on the outputs one clock later. A cycle without `instr_valid` produces an all-zero bubble. Fields that do not belong to the decoded class read as zero. Fetching the extension word and executing the instruction are the job of the surrounding pipeline.

Class codes on `dec_class`: 0 register+constant, 1 two-address, 2 one-address, 3 zero-address, 4 jump/branch, 5 decrement-and-branch. A memory operand field is `rrmm`. Bits 3:2 pick the address register, R12 to R15. Bits 1:0 pick the mode: 00 plain, 01 post-increment, 10 pre-decrement, 11 a special case that takes a 16-bit word.

Top module: `isa_fmt_decoder`

## Requirements
- R1: While `rst_n` is low, every output is zero.
- R2: `dec_valid` equals the `instr_valid` of the previous clock. After a cycle with `instr_valid` low, all other outputs are zero.
- R3: When bits 15:12 are in the range 0110 to 1111, the class is 0. The opcode is bits 15:12 minus 6, `dec_dst` is bits 11:8 and `dec_imm8` is bits 7:0. Both memory flags are 0, and the word is legal and needs no extension.
- R4: When bits 15:12 are 0100, the class is 4. The opcode is {0, bits 11:8}, where bits 11:9 are the condition select and bit 8 is the wanted value. `dec_offset` is bits 7:0.
- R5: When bits 15:12 are 0101, the class is 5. `dec_dst` is bits 11:8, `dec_offset` is bits 7:0 and the opcode is 0.
- R6: When bits 15:14 are 00 and bits 7:4 are nonzero, the class is 1. The opcode is {0, bits 7:4}, `dec_dst` is bits 11:8, `dec_dst_mem` is bit 12, `dec_src` is bits 3:0 and `dec_src_mem` is bit 13. Opcodes 12 to 15 are illegal.
- R7: When bits 15:14 are 00, bits 7:4 are zero, and bit 13 or bits 3:0 are nonzero, the class is 2. The opcode is {bit 13, bits 3:0}, `dec_dst` is bits 11:8 and `dec_dst_mem` is bit 12. Opcodes above 17 are illegal.
- R8: When bits 15:13 are 000 and bits 7:0 are zero, the class is 3 and the opcode is bits 12:8. Opcodes above 12 are illegal.
- R9: In a legal two- or one-address word, `dec_need_ext` is 1 when an operand flagged as memory has mode bits 1:0 equal to 11.
- R10: A legal zero-address word with opcode 2 to 12 sets `dec_need_ext`.
- R11: `dec_illegal` is 1 exactly for the undefined opcodes named in R6 to R8. An illegal word never sets `dec_need_ext`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| instr_valid | input | 1 | `instr` holds a word to decode |
| instr | input | 16 | Instruction word |
| dec_valid | output | 1 | Decoded result is present |
| dec_class | output | 3 | Class code |
| dec_opcode | output | 5 | Operation within the class |
| dec_dst | output | 4 | Destination register or memory field |
| dec_dst_mem | output | 1 | Destination is a memory operand |
| dec_src | output | 4 | Source register or memory field |
| dec_src_mem | output | 1 | Source is a memory operand |
| dec_imm8 | output | 8 | Short constant |
| dec_offset | output | 8 | Branch offset in words |
| dec_need_ext | output | 1 | A second 16-bit word must follow |
| dec_illegal | output | 1 | Opcode is undefined |

## Verification
The assertions rely on `instr` being a known value whenever `instr_valid` is high. They also rely on the result being taken only from the registered outputs one clock later. The bench meets both conditions: it changes inputs only on the falling edge, and it drives a defined word on every cycle, including bubbles. The stimulus starts with directed words at every class boundary, at every legality boundary and on each special memory mode. It then runs a long stretch of random words with `instr_valid` dropped at random, so every class and bubble appear many times next to one another.

// File: rtl/isa_dec_pkg.sv
package isa_dec_pkg;
    localparam int WORD_W  = 16;
    localparam int NIB_W   = 4;
    localparam int FIELD_W = 4;
    localparam int MODE_W  = 2;
    localparam int OPC_W   = 5;
    localparam int BYTE_W  = 8;
    localparam int CLASS_W = 3;

    localparam int RC_BASE        = 6;
    localparam int BR_NIB         = 4;
    localparam int DBN_NIB        = 5;
    localparam int TWO_LAST       = 11;
    localparam int ONE_LAST       = 17;
    localparam int ZERO_EXT_FIRST = 2;
    localparam int ZERO_LAST      = 12;

    typedef enum logic [CLASS_W-1:0] {
        CL_REGCONST = 3'd0,
        CL_TWO      = 3'd1,
        CL_ONE      = 3'd2,
        CL_ZERO     = 3'd3,
        CL_BRANCH   = 3'd4,
        CL_DECBR    = 3'd5
    } dec_class_e;

    typedef struct packed {
        logic               valid;
        dec_class_e         cls;
        logic [OPC_W-1:0]   opc;
        logic [FIELD_W-1:0] dst;
        logic               dst_mem;
        logic [FIELD_W-1:0] src;
        logic               src_mem;
        logic [BYTE_W-1:0]  imm;
        logic [BYTE_W-1:0]  off;
        logic               ext;
        logic               illegal;
    } dec_word_t;
endpackage

// File: rtl/isa_mem_probe.sv
module isa_mem_probe
    import isa_dec_pkg::*;
(
    input  logic               is_mem,
    input  logic [FIELD_W-1:0] field,
    output logic               special
);
    // Mode bits at the bottom of the operand field; all ones marks a special case.
    always_comb begin
        special = is_mem && (field[MODE_W-1:0] == {MODE_W{1'b1}});
    end
endmodule

// File: rtl/isa_op_legal.sv
module isa_op_legal
    import isa_dec_pkg::*;
(
    input  dec_class_e       cls,
    input  logic [OPC_W-1:0] opc,
    output logic             legal,
    output logic             op_ext
);
    always_comb begin
        legal  = 1'b1;
        op_ext = 1'b0;
        case (cls)
            CL_TWO:  legal = (opc != '0) && (opc <= OPC_W'(TWO_LAST));
            CL_ONE:  legal = (opc != '0) && (opc <= OPC_W'(ONE_LAST));
            CL_ZERO: begin
                legal  = (opc <= OPC_W'(ZERO_LAST));
                op_ext = (opc >= OPC_W'(ZERO_EXT_FIRST)) && (opc <= OPC_W'(ZERO_LAST));
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/isa_fmt_decoder.sv
module isa_fmt_decoder
    import isa_dec_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               instr_valid,
    input  logic [WORD_W-1:0]  instr,
    output logic               dec_valid,
    output logic [CLASS_W-1:0] dec_class,
    output logic [OPC_W-1:0]   dec_opcode,
    output logic [FIELD_W-1:0] dec_dst,
    output logic               dec_dst_mem,
    output logic [FIELD_W-1:0] dec_src,
    output logic               dec_src_mem,
    output logic [BYTE_W-1:0]  dec_imm8,
    output logic [BYTE_W-1:0]  dec_offset,
    output logic               dec_need_ext,
    output logic               dec_illegal
);
    localparam int NUM_OPERANDS = 2;

    dec_word_t raw_d;
    dec_word_t dec_d;
    dec_word_t dec_q;

    logic [NIB_W-1:0]  top_nib;
    logic [NIB_W-1:0]  mid_nib;
    logic [NIB_W-1:0]  low_nib;
    logic [FIELD_W-1:0] hi_field;
    logic              bit_s;
    logic              bit_d;

    assign top_nib  = instr[WORD_W-1 -: NIB_W];
    assign hi_field = instr[WORD_W-NIB_W-1 -: FIELD_W];
    assign mid_nib  = instr[2*NIB_W-1 -: NIB_W];
    assign low_nib  = instr[NIB_W-1:0];
    assign bit_s    = instr[WORD_W-3];
    assign bit_d    = instr[WORD_W-4];

    // Class sort and field extraction
    always_comb begin
        raw_d       = '0;
        raw_d.valid = instr_valid;
        if (instr_valid) begin
            if (top_nib >= NIB_W'(RC_BASE)) begin
                raw_d.cls = CL_REGCONST;
                raw_d.opc = OPC_W'(top_nib - NIB_W'(RC_BASE));
                raw_d.dst = hi_field;
                raw_d.imm = instr[BYTE_W-1:0];
            end else if (top_nib == NIB_W'(BR_NIB)) begin
                raw_d.cls = CL_BRANCH;
                raw_d.opc = {1'b0, hi_field};
                raw_d.off = instr[BYTE_W-1:0];
            end else if (top_nib == NIB_W'(DBN_NIB)) begin
                raw_d.cls = CL_DECBR;
                raw_d.dst = hi_field;
                raw_d.off = instr[BYTE_W-1:0];
            end else if (mid_nib != '0) begin
                raw_d.cls     = CL_TWO;
                raw_d.opc     = {1'b0, mid_nib};
                raw_d.dst     = hi_field;
                raw_d.dst_mem = bit_d;
                raw_d.src     = low_nib;
                raw_d.src_mem = bit_s;
            end else if (!bit_s && (low_nib == '0)) begin
                raw_d.cls = CL_ZERO;
                raw_d.opc = {bit_d, hi_field};
            end else begin
                raw_d.cls     = CL_ONE;
                raw_d.opc     = {bit_s, low_nib};
                raw_d.dst     = hi_field;
                raw_d.dst_mem = bit_d;
            end
        end
    end

    logic [NUM_OPERANDS-1:0]  op_is_mem;
    logic [FIELD_W-1:0]       op_field [NUM_OPERANDS];
    logic [NUM_OPERANDS-1:0]  op_special;
    logic                     opc_legal;
    logic                     opc_ext;

    assign op_is_mem[0] = raw_d.dst_mem;
    assign op_field[0]  = raw_d.dst;
    assign op_is_mem[1] = raw_d.src_mem;
    assign op_field[1]  = raw_d.src;

    for (genvar g = 0; g < NUM_OPERANDS; g++) begin : g_probe
        isa_mem_probe u_probe (
            .is_mem  (op_is_mem[g]),
            .field   (op_field[g]),
            .special (op_special[g])
        );
    end

    isa_op_legal u_legal (
        .cls    (raw_d.cls),
        .opc    (raw_d.opc),
        .legal  (opc_legal),
        .op_ext (opc_ext)
    );

    always_comb begin
        dec_d         = raw_d;
        dec_d.illegal = raw_d.valid && !opc_legal;
        dec_d.ext     = raw_d.valid && opc_legal && ((|op_special) || opc_ext);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) dec_q <= '0;
        else        dec_q <= dec_d;
    end

    assign dec_valid    = dec_q.valid;
    assign dec_class    = dec_q.cls;
    assign dec_opcode   = dec_q.opc;
    assign dec_dst      = dec_q.dst;
    assign dec_dst_mem  = dec_q.dst_mem;
    assign dec_src      = dec_q.src;
    assign dec_src_mem  = dec_q.src_mem;
    assign dec_imm8     = dec_q.imm;
    assign dec_offset   = dec_q.off;
    assign dec_need_ext = dec_q.ext;
    assign dec_illegal  = dec_q.illegal;

    // Checks on the registered result
    p_valid_follows_r2: assert property (@(posedge clk) disable iff (!rst_n)
        instr_valid |=> dec_valid);
    p_bubble_clear_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !instr_valid |=> (!dec_valid && dec_class == '0 && dec_opcode == '0 && !dec_need_ext));
    p_imm_only_regconst_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_imm8 != '0) |-> (dec_class == CL_REGCONST));
    p_offset_only_branch_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_offset != '0) |-> (dec_class == CL_BRANCH || dec_class == CL_DECBR));
    p_src_mem_two_r6: assert property (@(posedge clk) disable iff (!rst_n)
        dec_src_mem |-> (dec_class == CL_TWO));
    p_zero_range_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_valid && dec_class == CL_ZERO && !dec_illegal) |-> (dec_opcode <= OPC_W'(ZERO_LAST)));
    p_ext_legal_r11: assert property (@(posedge clk) disable iff (!rst_n)
        dec_need_ext |-> (dec_valid && !dec_illegal));
endmodule

// File: tb/isa_fmt_decoder_tb_top.sv
`timescale 1ns/1ps
module isa_fmt_decoder_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        instr_valid = 1'b0;
    logic [15:0] instr = 16'h0000;

    logic        dec_valid;
    logic [2:0]  dec_class;
    logic [4:0]  dec_opcode;
    logic [3:0]  dec_dst;
    logic        dec_dst_mem;
    logic [3:0]  dec_src;
    logic        dec_src_mem;
    logic [7:0]  dec_imm8;
    logic [7:0]  dec_offset;
    logic        dec_need_ext;
    logic        dec_illegal;

    always #2 clk = ~clk;

    isa_fmt_decoder dut_i (
        .clk(clk), .rst_n(rst_n), .instr_valid(instr_valid), .instr(instr),
        .dec_valid(dec_valid), .dec_class(dec_class), .dec_opcode(dec_opcode),
        .dec_dst(dec_dst), .dec_dst_mem(dec_dst_mem), .dec_src(dec_src),
        .dec_src_mem(dec_src_mem), .dec_imm8(dec_imm8), .dec_offset(dec_offset),
        .dec_need_ext(dec_need_ext), .dec_illegal(dec_illegal)
    );

    int checks = 0;
    int failures = 0;
    bit finished = 0;

    int e_v, e_cls, e_opc, e_dst, e_dm, e_src, e_sm, e_imm, e_off, e_ext, e_ill;
    string e_tag;

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // Behavioural reference: what the outputs must show one clock after word w.
    task automatic model(input bit v, input int w);
        int top, mid, lo, hi, bs, bd;
        e_v = v; e_cls = 0; e_opc = 0; e_dst = 0; e_dm = 0; e_src = 0; e_sm = 0;
        e_imm = 0; e_off = 0; e_ext = 0; e_ill = 0; e_tag = "R2";
        if (!v) return;
        top = w / 4096;
        hi  = (w / 256) % 16;
        mid = (w / 16) % 16;
        lo  = w % 16;
        bs  = (w / 8192) % 2;
        bd  = (w / 4096) % 2;
        if (top >= 6) begin
            e_tag = "R3"; e_cls = 0; e_opc = top - 6; e_dst = hi; e_imm = w % 256;
        end else if (top == 4) begin
            e_tag = "R4"; e_cls = 4; e_opc = hi; e_off = w % 256;
        end else if (top == 5) begin
            e_tag = "R5"; e_cls = 5; e_dst = hi; e_off = w % 256;
        end else if (mid != 0) begin
            e_tag = "R6"; e_cls = 1; e_opc = mid; e_dst = hi; e_dm = bd; e_src = lo; e_sm = bs;
            e_ill = (mid > 11);
            e_ext = !e_ill && ((bd == 1 && hi % 4 == 3) || (bs == 1 && lo % 4 == 3));
        end else if (bs == 0 && w % 256 == 0) begin
            e_tag = "R8"; e_cls = 3; e_opc = (w / 256) % 32;
            e_ill = (e_opc > 12);
            e_ext = (e_opc >= 2 && e_opc <= 12);
        end else begin
            e_tag = "R7"; e_cls = 2; e_opc = bs * 16 + lo; e_dst = hi; e_dm = bd;
            e_ill = (e_opc > 17);
            e_ext = !e_ill && bd == 1 && hi % 4 == 3;
        end
    endtask

    task automatic compare_all();
        chk("R2", "valid", dec_valid, e_v);
        chk(e_tag, "class", dec_class, e_cls);
        chk(e_tag, "opcode", dec_opcode, e_opc);
        chk(e_tag, "dst", dec_dst, e_dst);
        chk(e_tag, "dst_mem", dec_dst_mem, e_dm);
        chk(e_tag, "src", dec_src, e_src);
        chk(e_tag, "src_mem", dec_src_mem, e_sm);
        chk(e_tag, "imm8", dec_imm8, e_imm);
        chk(e_tag, "offset", dec_offset, e_off);
        chk(e_cls == 3 ? "R10" : "R9", "need_ext", dec_need_ext, e_ext);
        chk("R11", "illegal", dec_illegal, e_ill);
    endtask

    task automatic step(input bit v, input logic [15:0] w);
        @(negedge clk);
        compare_all();
        instr_valid = v;
        instr = w;
        model(v, int'(w));
    endtask

    logic [15:0] directed [0:20] = '{
        16'h6A55, 16'hF0FF, 16'h5FFF, 16'h4E80, 16'h4001, 16'h5381,
        16'h3B3F, 16'h0123, 16'h00C0, 16'h00B7, 16'h0105, 16'h2001,
        16'h2002, 16'h1F00, 16'h0C00, 16'h0100, 16'h0200, 16'h0D00,
        16'h1B07, 16'h0000, 16'h1311
    };

    initial begin
        repeat (3) @(negedge clk);
        // R1: outputs held at zero during reset
        chk("R1", "valid", dec_valid, 0);
        chk("R1", "class", dec_class, 0);
        chk("R1", "need_ext", dec_need_ext, 0);
        chk("R1", "illegal", dec_illegal, 0);
        chk("R1", "imm8", dec_imm8, 0);
        rst_n = 1'b1;
        model(0, 0);
        foreach (directed[i]) step(1'b1, directed[i]);
        step(1'b0, 16'hFFFF);
        begin
            int seed;
            seed = $urandom(32'h5eed);
            for (int k = 0; k < 4000; k++) begin
                int r;
                r = $urandom();
                step((r % 8) != 0, 16'($urandom()));
            end
        end
        step(1'b0, 16'h0000);
        step(1'b0, 16'h0000);
        if (!finished) begin
            finished = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        #100000;
        if (!finished) begin
            finished = 1;
            checks++;
            failures++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule